// File: doc/BRIEF.md
# Lockable Protected Region Checker

This block keeps two protected memory regions. Each region has a base, a size and a lock bit. The application processor programs them through a small register-write port. Region 0 is reserved for the secure coprocessor. Region 1 belongs to the main processor's trusted kernel-protection area. Once a lock bit is set it cannot be cleared, and the region's settings stay frozen until reset.

The secure side can only read. It sees every region's base, size and lock state, plus one flag that rises once every region is locked. Secure firmware polls that flag before it continues booting.

The block also answers three questions combinationally:
- Buffer validation: is a requested buffer (start address and byte length) wholly inside physical memory and clear of every protected region? The secure side asks this before copying untrusted data.
- Secure window: for a secure-view address, where does it land in region 0? Region 0 appears at a fixed window base in the secure view.
- Application-processor access: may the application processor touch a given address? Any address inside region 0 is denied.

Top module: `prot_region_guard`

## Requirements
- R1: After reset, every region's base and size read 0, every lock bit reads 0 and `all_locked_o` is 0.
- R2: A write with `wr_en` high updates the selected field, and the status outputs show the new value from the next clock edge. `wr_sel` is laid out as {region index, field}. The low two bits select the field: 0 is base, 1 is size, 2 is lock (taken from `wr_data[0]`), and 3 selects nothing, so that write changes no state.
- R3: A lock bit, once set, cannot be cleared by a write. While a region is locked, writes to its base, size and lock fields are ignored until reset.
- R4: `all_locked_o` is 1 exactly when every region's lock bit is set.
- R5: The buffer validator rejects a zero length. It also rejects a range whose last byte (start + length - 1) wraps past the top of the address space.
- R6: The validator accepts a range only if its first and last bytes both lie within [MEM_FIRST, MEM_LAST].
- R7: The validator rejects any range that shares at least one byte with a protected region, including a single-byte overlap at either end of the region. A range that ends immediately before a region, or starts immediately after one, is accepted. A region covers base through base + size - 1, clipped at the top of the address space.
- R8: A region whose size is 0 covers no address. It never causes a rejection, a window hit or an access denial.
- R9: A secure-view address in [WIN_BASE, WIN_BASE + size0) gives `win_hit` = 1 and `win_phys` = base0 + (address - WIN_BASE), but only while region 0 is locked. Any other address, or any address while region 0 is unlocked, gives `win_hit` = 0 and `win_phys` = 0.
- R10: `ap_allow` is 0 for an address inside region 0 and 1 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe from the application processor |
| wr_sel | input | SEL_W | {region index, field} select |
| wr_data | input | ADDR_W | Write data |
| reg_base_o | output | NR*ADDR_W | Region bases, region 0 in the low bits |
| reg_size_o | output | NR*ADDR_W | Region sizes, region 0 in the low bits |
| reg_lock_o | output | NR | Lock bits, one per region |
| all_locked_o | output | 1 | Every region is locked |
| chk_base | input | ADDR_W | Start address of the buffer to validate |
| chk_len | input | ADDR_W | Length in bytes of the buffer to validate |
| chk_ok | output | 1 | Buffer is acceptable |
| sec_addr | input | ADDR_W | Secure-view address to translate |
| win_hit | output | 1 | Address falls in the locked region 0 window |
| win_phys | output | ADDR_W | Translated physical address |
| ap_addr | input | ADDR_W | Application-processor access address |
| ap_allow | output | 1 | Access permitted |

## Verification
The only state is the region registers, so a corrupted base, size or lock bit appears on the status outputs at the first clock edge after the write that caused it. A lock that fails to stick, or a frozen field that still changes, shows up on the same cycle as a changed status word. The validator, window and access outputs are combinational over that state. An error in the bounds arithmetic is therefore visible immediately at `chk_ok`, `win_hit`, `win_phys` or `ap_allow` for ranges placed exactly on a region edge, a memory edge or the wrap point.

// File: rtl/prg_pkg.sv
package prg_pkg;
  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_LOCK = 2'd2,
    FLD_NONE = 2'd3
  } field_e;
endpackage

// File: rtl/prg_region_reg.sv
module prg_region_reg
  import prg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  field_e            fld,
  input  logic [ADDR_W-1:0] data,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] size_q,
  output logic              lock_q
);
  logic [ADDR_W-1:0] base_d, size_d;
  logic              lock_d;
  logic              upd;

  // a locked region accepts nothing
  assign upd = we && !lock_q;

  always_comb begin
    base_d = base_q;
    size_d = size_q;
    lock_d = lock_q;
    if (upd) begin
      case (fld)
        FLD_BASE: base_d = data;
        FLD_SIZE: size_d = data;
        FLD_LOCK: lock_d = data[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      lock_q <= 1'b0;
    end else if (upd) begin
      base_q <= base_d;
      size_q <= size_d;
      lock_q <= lock_d;
    end
  end

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(base_q) && $stable(size_q)));
endmodule

// File: rtl/prg_span_cmp.sv
module prg_span_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] rbase,
  input  logic [ADDR_W-1:0] rsize,
  output logic              overlap
);
  logic [ADDR_W:0]   rend_w;
  logic [ADDR_W-1:0] rhi;
  logic              nz;

  assign nz     = (rsize != '0);
  assign rend_w = {1'b0, rbase} + {1'b0, rsize} - {{ADDR_W{1'b0}}, 1'b1};
  // clip region end at the top of the address space
  assign rhi    = rend_w[ADDR_W] ? {ADDR_W{1'b1}} : rend_w[ADDR_W-1:0];

  assign overlap = nz && (lo <= rhi) && (rbase <= hi);
endmodule

// File: rtl/prg_window.sv
module prg_window #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
  input  logic [ADDR_W-1:0] sec_addr,
  input  logic [ADDR_W-1:0] rbase,
  input  logic [ADDR_W-1:0] rsize,
  input  logic              rlock,
  output logic              hit,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] off;

  assign off  = sec_addr - WIN_BASE;
  assign hit  = rlock && (sec_addr >= WIN_BASE) && (off < rsize);
  assign phys = hit ? (rbase + off) : '0;
endmodule

// File: rtl/prot_region_guard.sv
module prot_region_guard
  import prg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NR = 2,
  parameter logic [ADDR_W-1:0] MEM_FIRST = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] MEM_LAST  = 32'h8FFF_FFFF,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
  localparam int RIDX_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int SEL_W  = RIDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [ADDR_W-1:0]    wr_data,
  output logic [NR*ADDR_W-1:0] reg_base_o,
  output logic [NR*ADDR_W-1:0] reg_size_o,
  output logic [NR-1:0]        reg_lock_o,
  output logic                 all_locked_o,
  input  logic [ADDR_W-1:0]    chk_base,
  input  logic [ADDR_W-1:0]    chk_len,
  output logic                 chk_ok,
  input  logic [ADDR_W-1:0]    sec_addr,
  output logic                 win_hit,
  output logic [ADDR_W-1:0]    win_phys,
  input  logic [ADDR_W-1:0]    ap_addr,
  output logic                 ap_allow
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [RIDX_W-1:0] sel_idx;
  field_e            sel_fld;
  assign sel_idx = wr_sel[SEL_W-1:2];
  assign sel_fld = field_e'(wr_sel[1:0]);

  logic [ADDR_W-1:0] rb [NR];
  logic [ADDR_W-1:0] rs [NR];
  logic [NR-1:0]     rl;
  logic [NR-1:0]     ovl;

  // validator span
  logic [ADDR_W:0]   span_end_w;
  logic [ADDR_W-1:0] span_hi;
  logic              span_bad;
  logic              span_in_mem;

  assign span_end_w  = {1'b0, chk_base} + {1'b0, chk_len} - {{ADDR_W{1'b0}}, 1'b1};
  assign span_hi     = span_end_w[ADDR_W-1:0];
  assign span_bad    = (chk_len == '0) || span_end_w[ADDR_W];
  assign span_in_mem = (chk_base >= MEM_FIRST) && (span_hi <= MEM_LAST);

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic we_g;
    assign we_g = wr_en && (sel_idx == RIDX_W'(g));

    prg_region_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .we     (we_g),
      .fld    (sel_fld),
      .data   (wr_data),
      .base_q (rb[g]),
      .size_q (rs[g]),
      .lock_q (rl[g])
    );

    prg_span_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .lo      (chk_base),
      .hi      (span_hi),
      .rbase   (rb[g]),
      .rsize   (rs[g]),
      .overlap (ovl[g])
    );

    assign reg_base_o[g*ADDR_W +: ADDR_W] = rb[g];
    assign reg_size_o[g*ADDR_W +: ADDR_W] = rs[g];
  end

  assign reg_lock_o   = rl;
  assign all_locked_o = &rl;
  assign chk_ok       = !span_bad && span_in_mem && (ovl == '0);

  prg_window #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_win (
    .sec_addr (sec_addr),
    .rbase    (rb[0]),
    .rsize    (rs[0]),
    .rlock    (rl[0]),
    .hit      (win_hit),
    .phys     (win_phys)
  );

  logic ap_in_r0;
  prg_span_cmp #(.ADDR_W(ADDR_W)) u_ap (
    .lo      (ap_addr),
    .hi      (ap_addr),
    .rbase   (rb[0]),
    .rsize   (rs[0]),
    .overlap (ap_in_r0)
  );
  assign ap_allow = !ap_in_r0;

  assert_all_locked_by_write_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(all_locked_o) |-> $past(wr_en));
  assert_ok_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    chk_ok |-> (chk_len != '0));
  assert_ok_in_mem_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    chk_ok |-> (chk_base >= MEM_FIRST && chk_base <= MEM_LAST));
  assert_win_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    win_hit |-> reg_lock_o[0]);
endmodule

// File: tb/tb_prot_region_guard.sv
`timescale 1ns/1ps
module tb_prot_region_guard;
  localparam int AW = 32;
  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic [NR*AW-1:0] reg_base_o, reg_size_o;
  logic [NR-1:0] reg_lock_o;
  logic          all_locked_o;
  logic [AW-1:0] chk_base = '0, chk_len = '0;
  logic          chk_ok;
  logic [AW-1:0] sec_addr = '0;
  logic          win_hit;
  logic [AW-1:0] win_phys;
  logic [AW-1:0] ap_addr = '0;
  logic          ap_allow;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  prot_region_guard dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reg_base_o(reg_base_o), .reg_size_o(reg_size_o), .reg_lock_o(reg_lock_o),
    .all_locked_o(all_locked_o), .chk_base(chk_base), .chk_len(chk_len),
    .chk_ok(chk_ok), .sec_addr(sec_addr), .win_hit(win_hit), .win_phys(win_phys),
    .ap_addr(ap_addr), .ap_allow(ap_allow)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] b, input logic [AW-1:0] l);
    chk_base = b; chk_len = l; #1;
  endtask

  // {base, length, expected chk_ok}; region0 = 0x2000_0000 + 0x0100_0000, region1 = 0x3000_0000 + 0x1000
  localparam logic [64:0] VEC [13] = '{
    {32'h1000_0000, 32'h0000_0100, 1'b1},  // R6 first byte of memory
    {32'h0FFF_FFFF, 32'h0000_0010, 1'b0},  // R6 below memory
    {32'h8FFF_FFF0, 32'h0000_0010, 1'b1},  // R6 ends on last byte
    {32'h8FFF_FFF0, 32'h0000_0011, 1'b0},  // R6 one past the end
    {32'h1FFF_FF00, 32'h0000_0100, 1'b1},  // R7 ends just before region0
    {32'h1FFF_FF00, 32'h0000_0101, 1'b0},  // R7 one byte into region0
    {32'h2100_0000, 32'h0000_0010, 1'b1},  // R7 starts just after region0
    {32'h20FF_FFFF, 32'h0000_0001, 1'b0},  // R7 last byte of region0
    {32'h1000_0000, 32'h7000_0000, 1'b0},  // R7 spans both regions
    {32'h3000_0FFF, 32'h0000_0002, 1'b0},  // R7 last byte of region1
    {32'h3000_1000, 32'h0000_0004, 1'b1},  // R7 after region1
    {32'h1000_0000, 32'h0000_0000, 1'b0},  // R5 zero length
    {32'hFFFF_FFF0, 32'h0000_0020, 1'b0}   // R5 wrap
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 base", reg_base_o, 64'h0);
    check("R1 size", reg_size_o, 64'h0);
    check("R1 locks", {reg_lock_o, all_locked_o}, 64'h0);

    // R2 program region0 base, then field 3 must do nothing
    wr(3'b000, 32'h2000_0000);
    check("R2 base0", reg_base_o[31:0], 64'h2000_0000);
    wr(3'b011, 32'hDEAD_BEEF);
    check("R2 field3 no effect", {reg_base_o, reg_size_o, 30'h0, reg_lock_o}, {32'h0, 32'h2000_0000, 64'h0, 32'h0});

    // R8 zero-size region never matches
    probe(32'h2000_0000, 32'h10);
    check("R8 zero-size no reject", chk_ok, 1);
    ap_addr = 32'h2000_0000; #1;
    check("R8 zero-size allow", ap_allow, 1);

    wr(3'b001, 32'h0100_0000);
    wr(3'b100, 32'h3000_0000);
    wr(3'b101, 32'h0000_1000);
    check("R2 size0", reg_size_o[31:0], 64'h0100_0000);
    check("R2 region1", {reg_base_o[63:32], reg_size_o[63:32]}, {32'h3000_0000, 32'h0000_1000});

    // R9 unlocked window misses
    sec_addr = 32'h8000_0010; #1;
    check("R9 unlocked miss", {win_hit, win_phys}, 33'h0);

    // R10 access permission
    ap_addr = 32'h2000_0000; #1;
    check("R10 deny first", ap_allow, 0);
    ap_addr = 32'h20FF_FFFF; #1;
    check("R10 deny last", ap_allow, 0);
    ap_addr = 32'h1FFF_FFFF; #1;
    check("R10 allow below", ap_allow, 1);
    ap_addr = 32'h3000_0000; #1;
    check("R10 allow region1", ap_allow, 1);

    // table of validator vectors
    for (int i = 0; i < 13; i++) begin
      probe(VEC[i][64:33], VEC[i][32:1]);
      check($sformatf("R5/R6/R7 vector %0d", i), chk_ok, VEC[i][0]);
    end

    // R4 partial locking
    wr(3'b010, 32'h1);
    check("R4 one locked", {reg_lock_o, all_locked_o}, 3'b010);

    // R9 locked window
    sec_addr = 32'h8000_0010; #1;
    check("R9 hit", {win_hit, win_phys}, {1'b1, 32'h2000_0010});
    sec_addr = 32'h80FF_FFFF; #1;
    check("R9 last", {win_hit, win_phys}, {1'b1, 32'h20FF_FFFF});
    sec_addr = 32'h8100_0000; #1;
    check("R9 past end", {win_hit, win_phys}, 33'h0);
    sec_addr = 32'h7FFF_FFFF; #1;
    check("R9 below", {win_hit, win_phys}, 33'h0);

    // R3 frozen after lock
    wr(3'b000, 32'h4000_0000);
    wr(3'b001, 32'h0000_0010);
    wr(3'b010, 32'h0);
    check("R3 base frozen", reg_base_o[31:0], 64'h2000_0000);
    check("R3 size frozen", reg_size_o[31:0], 64'h0100_0000);
    check("R3 lock sticky", reg_lock_o[0], 1);

    // R4 all locked
    wr(3'b110, 32'h1);
    check("R4 all locked", {reg_lock_o, all_locked_o}, 3'b111);
    wr(3'b100, 32'h0);
    check("R3 region1 frozen", reg_base_o[63:32], 64'h3000_0000);

    // R1 reset again clears locks
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", {reg_lock_o, all_locked_o, reg_base_o}, 67'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'b000, 32'h5000_0000);
    check("R1 writable after reset", reg_base_o[31:0], 64'h5000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule